// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block resolves the control-flow outcome of one instruction per cycle in a 32-bit core whose instructions are 4 bytes long. It receives the current program counter, the operand A (the value tested against zero, or the base of a return address), the operand B (a register offset or target, or an immediate), a class select, a condition code, the link, absolute and delay flags, and a return kind. One clock later it presents the next program counter, a taken flag, a delay-slot flag, a link write carrying the old PC, and requests to set or clear the break-in-progress and interrupt-enable status bits.

Five classes are handled. Sequential instructions advance by 4. Jumps are always taken, either PC-relative or absolute, and may link. Conditional branches test A as a signed value against zero and either add B to the PC or advance by 4. Returns load A + B and always have a delay slot. Break loads an absolute target, links and raises break-in-progress. The fetch stage and pipeline flush logic that consume these outputs sit outside the block.

Top module: `bru_unit`

## Requirements
- R1: While rst_ni is low, valid_o, taken_o, delay_slot_o, link_we_o, set_bip_o, clr_bip_o and set_ie_o are 0, and next_pc_o equals RESET_PC (default 0). This holds whatever the inputs are.
- R2: A request with valid_i high at a rising edge produces its result one cycle later, with valid_o high. A cycle with valid_i low produces valid_o low, and all flag outputs are low in that case.
- R3: Class code 0 (sequential), and the unused class codes 5, 6 and 7, give next_pc_o = pc_i + 4 (modulo 2^32). In these cases taken_o, delay_slot_o, link_we_o and all status requests are 0.
- R4: Class code 1 (jump) with abs_i = 0 gives next_pc_o = pc_i + opb_i, and taken_o = 1.
- R5: Class code 1 with abs_i = 1 gives next_pc_o = opb_i, and taken_o = 1.
- R6: A jump with link_i = 1 raises link_we_o, and link_data_o equals the request's pc_i. A jump with link_i = 0 does not link, and a conditional branch never links.
- R7: Class code 2 (conditional) compares opa_i, taken as signed, with zero. The condition codes are 0 eq, 1 ne, 2 lt, 3 le, 4 gt and 5 ge. A true condition gives next_pc_o = pc_i + opb_i; a false one gives pc_i + 4.
- R8: For jumps and conditional branches, delay_slot_o equals delay_i, whether or not the branch is taken.
- R9: Class code 4 (break) gives next_pc_o = opb_i, taken_o = 1, link_we_o = 1 and set_bip_o = 1, and delay_slot_o = 0. The abs_i, link_i and delay_i inputs do not change this result.
- R10: Class code 3 (return) gives next_pc_o = opa_i + opb_i, taken_o = 1 and delay_slot_o = 1, even when delay_i = 0, and link_we_o = 0.
- R11: A return with ret_kind_i = 1 raises set_ie_o. A return with ret_kind_i = 2 raises clr_bip_o. Kinds 0 and 3 raise neither. At most one status request is high in any cycle.
- R12: taken_o is 0 only for sequential requests and for conditional branches whose condition is false.
- R13: Condition codes 6 and 7 are never true, so such a branch gives next_pc_o = pc_i + 4 with taken_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| pc_i | input | XLEN | Address of the current instruction |
| opa_i | input | XLEN | Condition source, or return base |
| opb_i | input | XLEN | Offset or target (register or immediate) |
| class_i | input | 3 | 0 seq, 1 jump, 2 cond, 3 return, 4 break |
| cond_i | input | 3 | 0 eq, 1 ne, 2 lt, 3 le, 4 gt, 5 ge |
| link_i | input | 1 | Jump writes the old PC to a register |
| abs_i | input | 1 | Jump target is opb_i rather than pc_i + opb_i |
| delay_i | input | 1 | Jump or branch has a delay slot |
| ret_kind_i | input | 2 | 0 plain, 1 from interrupt, 2 from break |
| valid_o | output | 1 | Result present |
| next_pc_o | output | XLEN | Resolved next PC |
| taken_o | output | 1 | Control flow redirected |
| delay_slot_o | output | 1 | Following instruction executes as delay slot |
| link_we_o | output | 1 | Write link_data_o to the destination register |
| link_data_o | output | XLEN | PC of the linking instruction |
| set_bip_o | output | 1 | Request to set break-in-progress |
| clr_bip_o | output | 1 | Request to clear break-in-progress |
| set_ie_o | output | 1 | Request to set interrupt-enable |

## Verification
The outputs are registered and the block holds no state across requests. A wrong decode or a wrong selection therefore shows at the ports in the cycle right after the request that caused it. A condition that is evaluated wrongly shows as an exchange between pc_i + 4 and pc_i + opb_i, with taken_o flipped. The bench uses A = 0, a positive value and a negative value with every condition code, and this separates the sign and zero terms. A wrong status request or delay-slot flag from a return or a break is visible at once on the flag outputs. If a flag leaks from a previous request, it shows as a nonzero flag in a cycle where valid_o is low.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_JUMP = 3'd1,
    CLS_COND = 3'd2,
    CLS_RET  = 3'd3,
    CLS_BRK  = 3'd4
  } bclass_e;

  typedef enum logic [2:0] {
    CC_EQ = 3'd0,
    CC_NE = 3'd1,
    CC_LT = 3'd2,
    CC_LE = 3'd3,
    CC_GT = 3'd4,
    CC_GE = 3'd5
  } ccode_e;

  typedef enum logic [1:0] {
    RK_PLAIN = 2'd0,
    RK_INTR  = 2'd1,
    RK_BRK   = 2'd2,
    RK_RSVD  = 2'd3
  } rkind_e;

  // target source select
  typedef enum logic [1:0] {
    TS_SEQ  = 2'd0,  // pc + step
    TS_REL  = 2'd1,  // pc + opb
    TS_ABS  = 2'd2,  // opb
    TS_BASE = 2'd3   // opa + opb
  } tsel_e;

  typedef struct packed {
    tsel_e tsel;
    logic  taken;
    logic  delay;
    logic  link_we;
    logic  set_bip;
    logic  clr_bip;
    logic  set_ie;
  } ctrl_t;

endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa_i,
  input  logic [2:0]      cond_i,
  output logic            hit_o
);

  logic is_zero;
  logic is_neg;

  assign is_zero = (opa_i == '0);
  assign is_neg  = opa_i[XLEN-1];

  always_comb begin
    unique case (cond_i)
      3'(CC_EQ): hit_o = is_zero;
      3'(CC_NE): hit_o = !is_zero;
      3'(CC_LT): hit_o = is_neg;
      3'(CC_LE): hit_o = is_neg || is_zero;
      3'(CC_GT): hit_o = !is_neg && !is_zero;
      3'(CC_GE): hit_o = !is_neg;
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  tsel_e           sel_i,
  output logic [XLEN-1:0] addr_o
);

  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] rel_addr;
  logic [XLEN-1:0] base_addr;

  assign seq_addr  = pc_i + STEP_V;
  assign rel_addr  = pc_i + opb_i;
  assign base_addr = opa_i + opb_i;

  always_comb begin
    unique case (sel_i)
      TS_SEQ:  addr_o = seq_addr;
      TS_REL:  addr_o = rel_addr;
      TS_ABS:  addr_o = opb_i;
      TS_BASE: addr_o = base_addr;
      default: addr_o = seq_addr;
    endcase
  end

endmodule

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
(
  input  logic [2:0] class_i,
  input  logic       hit_i,
  input  logic       link_i,
  input  logic       abs_i,
  input  logic       delay_i,
  input  logic [1:0] ret_kind_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o = '{tsel: TS_SEQ, default: 1'b0};
    unique case (class_i)
      3'(CLS_JUMP): begin
        ctrl_o.tsel    = abs_i ? TS_ABS : TS_REL;
        ctrl_o.taken   = 1'b1;
        ctrl_o.delay   = delay_i;
        ctrl_o.link_we = link_i;
      end
      3'(CLS_COND): begin
        ctrl_o.tsel  = hit_i ? TS_REL : TS_SEQ;
        ctrl_o.taken = hit_i;
        ctrl_o.delay = delay_i;
      end
      3'(CLS_RET): begin
        ctrl_o.tsel    = TS_BASE;
        ctrl_o.taken   = 1'b1;
        ctrl_o.delay   = 1'b1;
        ctrl_o.set_ie  = (ret_kind_i == 2'(RK_INTR));
        ctrl_o.clr_bip = (ret_kind_i == 2'(RK_BRK));
      end
      3'(CLS_BRK): begin
        ctrl_o.tsel    = TS_ABS;
        ctrl_o.taken   = 1'b1;
        ctrl_o.link_we = 1'b1;
        ctrl_o.set_bip = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              STEP     = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [2:0]      class_i,
  input  logic [2:0]      cond_i,
  input  logic            link_i,
  input  logic            abs_i,
  input  logic            delay_i,
  input  logic [1:0]      ret_kind_i,
  output logic            valid_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            delay_slot_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_data_o,
  output logic            set_bip_o,
  output logic            clr_bip_o,
  output logic            set_ie_o
);

  logic            hit;
  ctrl_t           ctrl;
  logic [XLEN-1:0] target;

  bru_cond #(.XLEN(XLEN)) u_cond (
    .opa_i  (opa_i),
    .cond_i (cond_i),
    .hit_o  (hit)
  );

  bru_ctrl u_ctrl (
    .class_i    (class_i),
    .hit_i      (hit),
    .link_i     (link_i),
    .abs_i      (abs_i),
    .delay_i    (delay_i),
    .ret_kind_i (ret_kind_i),
    .ctrl_o     (ctrl)
  );

  bru_target #(.XLEN(XLEN), .STEP(STEP)) u_target (
    .pc_i   (pc_i),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .sel_i  (ctrl.tsel),
    .addr_o (target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      next_pc_o    <= RESET_PC;
      taken_o      <= 1'b0;
      delay_slot_o <= 1'b0;
      link_we_o    <= 1'b0;
      link_data_o  <= '0;
      set_bip_o    <= 1'b0;
      clr_bip_o    <= 1'b0;
      set_ie_o     <= 1'b0;
    end else begin
      valid_o      <= valid_i;
      taken_o      <= valid_i & ctrl.taken;
      delay_slot_o <= valid_i & ctrl.delay;
      link_we_o    <= valid_i & ctrl.link_we;
      set_bip_o    <= valid_i & ctrl.set_bip;
      clr_bip_o    <= valid_i & ctrl.clr_bip;
      set_ie_o     <= valid_i & ctrl.set_ie;
      if (valid_i) begin
        next_pc_o   <= target;
        link_data_o <= pc_i;
      end
    end
  end

endmodule

// File: rtl/bru_unit_chk.sv
module bru_unit_chk #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] opb_i,
  input logic [2:0]      class_i,
  input logic            link_i,
  input logic            valid_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            delay_slot_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_data_o,
  input logic            set_bip_o,
  input logic            clr_bip_o,
  input logic            set_ie_o
);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !taken_o && !link_we_o && !set_bip_o && !clr_bip_o && !set_ie_o));

  p_seq_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 3'd0) |=> (next_pc_o == $past(pc_i) + XLEN'(STEP) && !taken_o));

  p_jump_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 3'd1 && link_i) |=> (link_we_o && link_data_o == $past(pc_i)));

  p_cond_nolink_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 3'd2) |=> !link_we_o);

  p_brk_effects_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 3'd4) |=> (set_bip_o && link_we_o && taken_o && !delay_slot_o
                                       && next_pc_o == $past(opb_i)));

  p_ret_slot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == 3'd3) |=> (delay_slot_o && taken_o && !link_we_o));

  p_status_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({set_bip_o, clr_bip_o, set_ie_o}) <= 1);

endmodule

bind bru_unit bru_unit_chk #(.XLEN(XLEN), .STEP(STEP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .pc_i         (pc_i),
  .opb_i        (opb_i),
  .class_i      (class_i),
  .link_i       (link_i),
  .valid_o      (valid_o),
  .next_pc_o    (next_pc_o),
  .taken_o      (taken_o),
  .delay_slot_o (delay_slot_o),
  .link_we_o    (link_we_o),
  .link_data_o  (link_data_o),
  .set_bip_o    (set_bip_o),
  .clr_bip_o    (clr_bip_o),
  .set_ie_o     (set_ie_o)
);

// File: tb/sim_bru_unit.sv
`timescale 1ns/1ps
module sim_bru_unit;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0;
  logic [2:0]  class_i = '0, cond_i = '0;
  logic        link_i = 1'b0, abs_i = 1'b0, delay_i = 1'b0;
  logic [1:0]  ret_kind_i = '0;
  logic        valid_o, taken_o, delay_slot_o, link_we_o, set_bip_o, clr_bip_o, set_ie_o;
  logic [31:0] next_pc_o, link_data_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit run     = 1'b0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] npc;
    logic        tk, dl, lw, sb, cb, ie;
    logic [31:0] ld;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  bru_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .pc_i(pc_i), .opa_i(opa_i),
    .opb_i(opb_i), .class_i(class_i), .cond_i(cond_i), .link_i(link_i), .abs_i(abs_i),
    .delay_i(delay_i), .ret_kind_i(ret_kind_i), .valid_o(valid_o), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .delay_slot_o(delay_slot_o), .link_we_o(link_we_o),
    .link_data_o(link_data_o), .set_bip_o(set_bip_o), .clr_bip_o(clr_bip_o),
    .set_ie_o(set_ie_o)
  );

  function automatic exp_t model(logic [31:0] pc, a, b, logic [2:0] cls, cc,
                                 logic lnk, ab, dly, logic [1:0] rk, string tag);
    exp_t e;
    logic hit;
    e = '{npc: pc + 32'd4, tk: 0, dl: 0, lw: 0, sb: 0, cb: 0, ie: 0, ld: pc, tag: tag};
    case (cls)
      3'd1: begin e.tk = 1; e.dl = dly; e.lw = lnk; e.npc = ab ? b : pc + b; end
      3'd2: begin
        case (cc)
          3'd0: hit = ($signed(a) == 0);
          3'd1: hit = ($signed(a) != 0);
          3'd2: hit = ($signed(a) < 0);
          3'd3: hit = ($signed(a) <= 0);
          3'd4: hit = ($signed(a) > 0);
          3'd5: hit = ($signed(a) >= 0);
          default: hit = 0;
        endcase
        e.tk = hit; e.dl = dly;
        if (hit) e.npc = pc + b;
      end
      3'd3: begin e.tk = 1; e.dl = 1; e.npc = a + b; e.ie = (rk == 2'd1); e.cb = (rk == 2'd2); end
      3'd4: begin e.tk = 1; e.lw = 1; e.sb = 1; e.npc = b; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic send(logic [31:0] pc, a, b, logic [2:0] cls, cc,
                      logic lnk, ab, dly, logic [1:0] rk, string tag);
    @(negedge clk);
    valid_i = 1; pc_i = pc; opa_i = a; opb_i = b; class_i = cls; cond_i = cc;
    link_i = lnk; abs_i = ab; delay_i = dly; ret_kind_i = rk;
    sb_q.push_back(model(pc, a, b, cls, cc, lnk, ab, dly, rk, tag));
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 0; class_i = 3'($urandom_range(0, 7)); link_i = 1; delay_i = 1;
    end
  endtask

  // monitor: pops one expected item per valid result
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (run) begin
        n_tests++;
        if (valid_o) begin
          if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL R2 unexpected result actual valid_o=1 expected valid_o=0");
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (next_pc_o !== e.npc || taken_o !== e.tk || delay_slot_o !== e.dl ||
                link_we_o !== e.lw || set_bip_o !== e.sb || clr_bip_o !== e.cb ||
                set_ie_o !== e.ie || (e.lw && link_data_o !== e.ld)) begin
              n_fail++;
              $display("FAIL %s actual npc=%h tk=%b dl=%b lw=%b ld=%h sb=%b cb=%b ie=%b expected npc=%h tk=%b dl=%b lw=%b ld=%h sb=%b cb=%b ie=%b",
                       e.tag, next_pc_o, taken_o, delay_slot_o, link_we_o, link_data_o,
                       set_bip_o, clr_bip_o, set_ie_o, e.npc, e.tk, e.dl, e.lw, e.ld,
                       e.sb, e.cb, e.ie);
            end
          end
        end else if (taken_o || delay_slot_o || link_we_o || set_bip_o || clr_bip_o || set_ie_o) begin
          n_fail++;
          $display("FAIL R2 idle flags actual tk=%b dl=%b lw=%b sb=%b cb=%b ie=%b expected all 0",
                   taken_o, delay_slot_o, link_we_o, set_bip_o, clr_bip_o, set_ie_o);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] avals [3];
    avals[0] = 32'd0; avals[1] = 32'd5; avals[2] = 32'hFFFF_FFF9;

    // R1: reset dominates active inputs
    valid_i = 1; class_i = 3'd4; opb_i = 32'h1234_5678;
    repeat (3) @(negedge clk);
    n_tests++;
    if (valid_o !== 0 || next_pc_o !== 32'h0 || taken_o || delay_slot_o || link_we_o ||
        set_bip_o || clr_bip_o || set_ie_o) begin
      n_fail++;
      $display("FAIL R1 reset actual v=%b npc=%h tk=%b expected v=0 npc=00000000 tk=0",
               valid_o, next_pc_o, taken_o);
    end
    valid_i = 0;
    rst_ni = 1;
    @(negedge clk);
    run = 1;

    // R3: sequential, unused classes, wrap
    send(32'h0000_1000, 0, 32'h40, 3'd0, 0, 1, 1, 1, 1, "R3");
    send(32'hFFFF_FFFC, 0, 0, 3'd0, 0, 0, 0, 0, 0, "R3");
    for (int c = 5; c < 8; c++) send(32'h200, 7, 8, 3'(c), 0, 1, 1, 1, 2, "R3");
    idle(2);

    // R4, R5, R6, R8: jumps
    send(32'h0000_2000, 0, 32'h0000_0100, 3'd1, 0, 0, 0, 0, 0, "R4");
    send(32'h0000_2000, 0, 32'hFFFF_FF00, 3'd1, 0, 0, 0, 1, 0, "R4");
    send(32'h0000_2000, 0, 32'h0000_8000, 3'd1, 0, 0, 1, 0, 0, "R5");
    send(32'h0000_3000, 0, 32'h0000_0040, 3'd1, 0, 1, 0, 1, 0, "R6");
    send(32'h0000_3004, 0, 32'h0000_9000, 3'd1, 0, 1, 1, 0, 0, "R6");
    send(32'h0000_3008, 0, 32'h0000_0010, 3'd1, 0, 0, 0, 1, 0, "R8");
    idle(1);

    // R7, R8, R12: every condition with zero, positive, negative A
    for (int c = 0; c < 6; c++)
      for (int v = 0; v < 3; v++) begin
        send(32'h0000_4000 + 32'(c * 16), avals[v], 32'h0000_0080, 3'd2, 3'(c),
             1, 0, 1'(v == 1), 0, (v == 1) ? "R8" : "R7");
        send(32'h0000_5000, avals[v], 32'hFFFF_FFF0, 3'd2, 3'(c), 0, 1, 1'(v != 1), 0, "R12");
      end
    send(32'h0000_6000, 32'h8000_0000, 32'h20, 3'd2, 3'd2, 0, 0, 0, 0, "R7");
    send(32'h0000_6000, 32'h7FFF_FFFF, 32'h20, 3'd2, 3'd4, 0, 0, 0, 0, "R7");

    // R13: reserved condition codes
    for (int v = 0; v < 3; v++) begin
      send(32'h0000_7000, avals[v], 32'h100, 3'd2, 3'd6, 0, 0, 0, 0, "R13");
      send(32'h0000_7000, avals[v], 32'h100, 3'd2, 3'd7, 0, 0, 1, 0, "R13");
    end
    idle(1);

    // R9: break ignores abs, link, delay
    send(32'h0000_8000, 5, 32'h0000_0018, 3'd4, 0, 0, 0, 0, 0, "R9");
    send(32'h0000_8004, 5, 32'h0000_0060, 3'd4, 0, 1, 1, 1, 3, "R9");

    // R10, R11: returns of each kind
    send(32'h0000_9000, 32'h0000_1000, 32'h8, 3'd3, 0, 1, 1, 0, 0, "R10");
    send(32'h0000_9000, 32'h0000_2000, 32'h4, 3'd3, 0, 0, 0, 0, 1, "R11");
    send(32'h0000_9000, 32'h0000_3000, 32'h8, 3'd3, 0, 0, 0, 1, 2, "R11");
    send(32'h0000_9000, 32'hFFFF_FFF8, 32'h10, 3'd3, 0, 0, 0, 0, 3, "R11");
    idle(4);

    n_tests++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 pending results actual=%0d expected=0", sb_q.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule